// File: doc/BRIEF.md
# Interrupt Request and Service Core

This block is the arbitration datapath of an eight-line interrupt controller. It watches a set of request pins. A rising edge on an unmasked pin records a pending request. When that request can be forwarded, the block emits a one-cycle interrupt pulse toward the processor. A separate command sequencer supplies the configuration: the mask, the vector base, the cascade map and the auto end-of-interrupt switch. The sequencer also sends end-of-interrupt strobes and an initialisation strobe.

When the processor acknowledges, the block serves the highest-numbered pending line. It clears that line's pending bit and either marks the line in service or retires it at once, depending on the auto end-of-interrupt switch. In the same cycle it returns an interrupt vector. If the chosen line has a downstream controller cascaded onto it, the vector that controller supplies is returned instead. The pending and in-service registers are visible on output ports so that a register-read path can return them.

Top module: `irq_serve_core`

## Requirements
- R1: A pending bit is set only when its pin goes from low to high, judged against the pin value stored on the previous clock edge. A pin that stays high raises no new request, even after its pending bit has been cleared.
- R2: A rising edge on a line whose `cfg_mask` bit is 1 is discarded, and the pending bit for that line stays 0.
- R3: `irq_pulse` is high for exactly the cycle after the edge on which a new request is recorded, and only if every in-service bit from that line number up to line 7 is 0. Otherwise it stays low.
- R4: On an acknowledge with requests pending, the highest-numbered pending line is chosen and its pending bit is cleared on the next edge.
- R5: With `cfg_auto_eoi` at 0, an acknowledge sets the chosen line's in-service bit. With `cfg_auto_eoi` at 1, the in-service bit is left clear and the acknowledge acts as an end-of-interrupt, so the highest remaining pending line is re-checked for forwarding as in R3.
- R6: The vector is the chosen line number placed in bits 2:0, with bits 7:3 taken from `cfg_vec_base`. Bits 2:0 of the base are ignored.
- R7: When the chosen line's `cfg_cascade` bit is 1, `ack_vector` equals `slave_vector`.
- R8: An end-of-interrupt strobe clears the in-service bit selected by `eoi_line`. If any pending bit is set, `irq_pulse` rises in the next cycle when no in-service bit remains at or above the highest pending line.
- R9: `ack_vector` is valid in the same cycle as `ack_strobe`, through a combinational path from the registers.
- R10: An acknowledge with no pending bits returns the base vector with line 0 and changes neither register.
- R11: `init_strobe` clears both the pending and the in-service registers on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pins | input | 8 | Request pins, one per line |
| cfg_mask | input | 8 | 1 disables capture on that line |
| cfg_vec_base | input | 8 | Vector base; bits 2:0 ignored |
| cfg_cascade | input | 8 | 1 marks a line that carries a cascaded controller |
| cfg_auto_eoi | input | 1 | Retire lines at acknowledge |
| init_strobe | input | 1 | Clear pending and in-service state |
| eoi_strobe | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 3 | Line retired by the strobe |
| ack_strobe | input | 1 | Single-cycle acknowledge |
| slave_vector | input | 8 | Vector from the cascaded controller |
| ack_vector | output | 8 | Vector for the current acknowledge |
| irq_pulse | output | 1 | One-cycle interrupt to the processor |
| req_bits | output | 8 | Pending register |
| isr_bits | output | 8 | In-service register |

## Verification
The bench builds the core with its defaults: eight lines, an eight-bit vector and the cascade path enabled (`HAS_SLAVE` = 1). This makes line 7 reachable, so the highest-line priority and the "at or above" forwarding gate can be tested across the full line range. With the cascade path present, the bench can also compare the slave substitution against the locally built vector. A base whose low bits are all ones exposes any leak of those bits into the vector.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
   localparam int DEF_LINES = 8;
   localparam int DEF_VEC_W = 8;

   function automatic int line_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int NUM_LINES = irq_core_pkg::DEF_LINES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pins,
   input  logic [NUM_LINES-1:0] mask,
   output logic [NUM_LINES-1:0] rise
);
   logic [NUM_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins;
   end

   assign rise = pins & ~prev_q & ~mask;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_LINES = irq_core_pkg::DEF_LINES,
   localparam int LINE_W   = irq_core_pkg::line_bits(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] vec,
   output logic [LINE_W-1:0]    idx,
   output logic                 any
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (vec[i]) idx = LINE_W'(i);
   end
   assign any = |vec;
endmodule

// File: rtl/irq_fwd_gate.sv
module irq_fwd_gate #(
   parameter int NUM_LINES = irq_core_pkg::DEF_LINES
) (
   input  logic [NUM_LINES-1:0] isr,
   output logic [NUM_LINES-1:0] ok
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign ok[l] = ~|isr[NUM_LINES-1:l];
   end
endmodule

// File: rtl/irq_serve_core.sv
module irq_serve_core #(
   parameter int NUM_LINES = irq_core_pkg::DEF_LINES,
   parameter int VEC_W     = irq_core_pkg::DEF_VEC_W,
   parameter bit HAS_SLAVE = 1'b1,
   localparam int LINE_W   = irq_core_pkg::line_bits(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_pins,
   input  logic [NUM_LINES-1:0] cfg_mask,
   input  logic [VEC_W-1:0]     cfg_vec_base,
   input  logic [NUM_LINES-1:0] cfg_cascade,
   input  logic                 cfg_auto_eoi,
   input  logic                 init_strobe,
   input  logic                 eoi_strobe,
   input  logic [LINE_W-1:0]    eoi_line,
   input  logic                 ack_strobe,
   input  logic [VEC_W-1:0]     slave_vector,
   output logic [VEC_W-1:0]     ack_vector,
   output logic                 irq_pulse,
   output logic [NUM_LINES-1:0] req_bits,
   output logic [NUM_LINES-1:0] isr_bits
);
   if (NUM_LINES < 2 || (1 << LINE_W) != NUM_LINES) begin : g_chk_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (VEC_W <= LINE_W) begin : g_chk_vec
      $error("VEC_W must exceed the line index width");
   end

   logic [NUM_LINES-1:0] req_q, isr_q, req_next, isr_next;
   logic                 pulse_q;
   logic [NUM_LINES-1:0] rise, ok_now, ok_eoi;
   logic [LINE_W-1:0]    sel_idx, rest_idx;
   logic                 req_any, rest_any;
   logic [NUM_LINES-1:0] sel_bit, eoi_bit, isr_eoi, req_rest;
   logic                 do_ack, fwd_new, fwd_eoi, fwd_auto;

   irq_edge_latch #(.NUM_LINES(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pins(irq_pins), .mask(cfg_mask), .rise(rise));

   irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick_sel (
      .vec(req_q), .idx(sel_idx), .any(req_any));

   irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick_rest (
      .vec(req_rest), .idx(rest_idx), .any(rest_any));

   irq_fwd_gate #(.NUM_LINES(NUM_LINES)) u_gate_now (
      .isr(isr_q), .ok(ok_now));

   irq_fwd_gate #(.NUM_LINES(NUM_LINES)) u_gate_eoi (
      .isr(isr_eoi), .ok(ok_eoi));

   always_comb begin
      sel_bit  = req_any ? (NUM_LINES'(1) << sel_idx) : '0;
      eoi_bit  = eoi_strobe ? (NUM_LINES'(1) << eoi_line) : '0;
      do_ack   = ack_strobe & req_any;
      req_rest = req_q & ~sel_bit;
      isr_eoi  = isr_q & ~eoi_bit;
      fwd_new  = |(rise & ok_now);
      fwd_eoi  = eoi_strobe & req_any & ok_eoi[sel_idx];
      fwd_auto = do_ack & cfg_auto_eoi & rest_any & ok_now[rest_idx];
      req_next = (req_q & ~(do_ack ? sel_bit : '0)) | rise;
      isr_next = isr_eoi | ((do_ack & ~cfg_auto_eoi) ? sel_bit : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= '0;
         isr_q   <= '0;
         pulse_q <= 1'b0;
      end else if (init_strobe) begin
         req_q   <= '0;
         isr_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         req_q   <= req_next;
         isr_q   <= isr_next;
         pulse_q <= fwd_new | fwd_eoi | fwd_auto;
      end
   end

   logic [VEC_W-1:0] local_vec;
   assign local_vec = {cfg_vec_base[VEC_W-1:LINE_W], sel_idx};

   if (HAS_SLAVE) begin : g_cascade
      assign ack_vector = (req_any && cfg_cascade[sel_idx]) ? slave_vector : local_vec;
   end else begin : g_local
      assign ack_vector = local_vec;
   end

   assign irq_pulse = pulse_q;
   assign req_bits  = req_q;
   assign isr_bits  = isr_q;

   AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((req_q & ~$past(req_q) & $past(cfg_mask)) == '0)); // R2

   AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_strobe && req_any && !init_strobe && !rise[sel_idx])
      |=> !req_q[$past(sel_idx)]); // R4

   AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_strobe && req_any && !cfg_auto_eoi && !init_strobe)
      |=> isr_q[$past(sel_idx)]); // R5

   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_strobe && !init_strobe &&
       !(ack_strobe && req_any && !cfg_auto_eoi && sel_idx == eoi_line))
      |=> !isr_q[$past(eoi_line)]); // R8

   AST_EMPTY_ACK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_strobe && !req_any && !eoi_strobe && !init_strobe)
      |=> (isr_q == $past(isr_q))); // R10

   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_strobe |=> (req_q == '0 && isr_q == '0)); // R11
endmodule

// File: tb/irq_serve_core_tb_top.sv
module irq_serve_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_pins = '0, cfg_mask = '0, cfg_vec_base = 8'h2F, cfg_cascade = 8'h04;
   logic       cfg_auto_eoi = 1'b0, init_strobe = 1'b0, eoi_strobe = 1'b0, ack_strobe = 1'b0;
   logic [2:0] eoi_line = '0;
   logic [7:0] slave_vector = 8'h75;
   logic [7:0] ack_vector, req_bits, isr_bits;
   logic       irq_pulse;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   always #10 clk = ~clk;

   irq_serve_core dut_i (
      .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .cfg_mask(cfg_mask),
      .cfg_vec_base(cfg_vec_base), .cfg_cascade(cfg_cascade), .cfg_auto_eoi(cfg_auto_eoi),
      .init_strobe(init_strobe), .eoi_strobe(eoi_strobe), .eoi_line(eoi_line),
      .ack_strobe(ack_strobe), .slave_vector(slave_vector), .ack_vector(ack_vector),
      .irq_pulse(irq_pulse), .req_bits(req_bits), .isr_bits(isr_bits));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: vector sampled mid-cycle while the acknowledge is held (R9)
   always @(negedge clk) begin
      if (ack_strobe && rst_n) begin
         if (exp_q.size() == 0) check("R9 unexpected ack", ack_vector, 8'hxx);
         else check("R9 vector", ack_vector, exp_q.pop_front());
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic raise(input int l);
      irq_pins[l] = 1'b1; step();
   endtask

   task automatic ack(input logic [7:0] expv);
      exp_q.push_back(expv);
      ack_strobe = 1'b1; step(); ack_strobe = 1'b0;
   endtask

   task automatic eoi(input logic [2:0] l);
      eoi_line = l; eoi_strobe = 1'b1; step(); eoi_strobe = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      check("R11 reset req", req_bits, 8'h00);
      check("R11 reset isr", isr_bits, 8'h00);
      check("R3 reset pulse", {7'b0, irq_pulse}, 8'h00);

      raise(3);
      check("R1 edge latched", req_bits, 8'h08);
      check("R3 pulse on free line", {7'b0, irq_pulse}, 8'h01);
      step();
      check("R3 pulse one cycle", {7'b0, irq_pulse}, 8'h00);
      check("R1 held pin no re-request", req_bits, 8'h08);

      ack(8'h2B);  // R6: base low bits ignored
      check("R4 req cleared", req_bits, 8'h00);
      check("R5 isr set", isr_bits, 8'h08);
      step();
      check("R1 held pin after clear", req_bits, 8'h00);

      raise(1);
      check("R3 blocked by higher isr", {7'b0, irq_pulse}, 8'h00);
      check("R1 second line", req_bits, 8'h02);
      raise(5);
      check("R3 pulse above isr", {7'b0, irq_pulse}, 8'h01);
      check("R4 two pending", req_bits, 8'h22);

      ack(8'h2D);
      check("R4 highest chosen", req_bits, 8'h02);
      check("R5 isr two lines", isr_bits, 8'h28);

      eoi(3'd5);
      check("R8 eoi clears", isr_bits, 8'h08);
      check("R8 still blocked", {7'b0, irq_pulse}, 8'h00);
      eoi(3'd3);
      check("R8 eoi clears last", isr_bits, 8'h00);
      check("R8 recheck forwards", {7'b0, irq_pulse}, 8'h01);

      ack(8'h29);
      check("R5 isr line1", isr_bits, 8'h02);
      ack(8'h28);  // R10 empty acknowledge
      check("R10 req unchanged", req_bits, 8'h00);
      check("R10 isr unchanged", isr_bits, 8'h02);

      cfg_mask = 8'h80;
      raise(7);
      check("R2 masked dropped", req_bits, 8'h00);
      check("R2 masked no pulse", {7'b0, irq_pulse}, 8'h00);
      cfg_mask = 8'h00;
      step();
      check("R1 unmask held pin", req_bits, 8'h00);
      irq_pins[7] = 1'b0; step();

      raise(2);
      check("R3 pulse line2", {7'b0, irq_pulse}, 8'h01);
      ack(8'h75);  // R7 cascade substitution
      check("R7 isr after cascade", isr_bits, 8'h06);

      eoi(3'd2);
      eoi(3'd1);
      check("R8 no pending no pulse", {7'b0, irq_pulse}, 8'h00);
      cfg_auto_eoi = 1'b1;
      irq_pins[4] = 1'b1; irq_pins[6] = 1'b1; step();
      check("R1 two edges", req_bits, 8'h50);
      ack(8'h2E);
      check("R5 auto isr clear", isr_bits, 8'h00);
      check("R5 auto req rest", req_bits, 8'h10);
      check("R5 auto recheck pulse", {7'b0, irq_pulse}, 8'h01);

      cfg_auto_eoi = 1'b0;
      raise(0);
      check("R1 line0", req_bits, 8'h11);
      ack(8'h2C);
      check("R5 isr line4", isr_bits, 8'h10);
      init_strobe = 1'b1; step(); init_strobe = 1'b0;
      check("R11 init req", req_bits, 8'h00);
      check("R11 init isr", isr_bits, 8'h00);
      step();
      check("R9 all acks consumed", 8'(exp_q.size()), 8'h00);
      finish_run();
   end
endmodule